// File: doc/BRIEF.md
# GPIO Pin Function Multiplexer with Data Latch

This block controls a bank of general-purpose pins, each of which can be handed to the local GPIO logic or to one of three peripherals. Every pin has a 2-bit function select. The select decides where the pad output value and the pad output enable come from. In GPIO mode both come from the block's own data and direction latches. In any of the three peripheral modes both come from the chosen peripheral.

The data latch can be changed in two ways. A register write replaces the whole latch. Three mask ports set, clear or invert individual bits, and each of them changes only the bits where it carries a 1. The pad input level is always passed to all three peripheral input buses, whatever the select. Reading the data address returns the pad level, not the latch content.

Software reaches the latches through a small register interface. It has a 2-bit address, a write enable, write data and a combinational read data output.

Top module: `gpio_mux_bank`

## Requirements
- R1: With a pin's select field at 00, its pad output equals its data latch bit and its pad output enable equals its direction bit (1 = drive, 0 = input).
- R2: With a pin's select field at k (01, 10 or 11), its pad output and pad output enable equal bit (k-1)*8+pin of `periphOut` and of `periphOe`, with peripheral 1 in the lowest 8 bits.
- R3: `periphIn` always equals three copies of `padIn`, with bit (k-1)*8+pin carrying pad pin for peripheral k, regardless of any select value.
- R4: A write to address 0 loads write data bits 7:0 into the data latch. A read of address 0 returns `padIn` in bits 7:0 and zeros above.
- R5: A 1 in `setMask` forces that data latch bit to 1 at the next clock edge, and a 0 leaves the bit alone.
- R6: A 1 in `clrMask` forces that data latch bit to 0 at the next clock edge. It takes priority over a set, a toggle and a register write to the same bit in the same cycle.
- R7: A 1 in `tglMask` inverts that data latch bit. When a register write to address 0 happens in the same cycle, it inverts the written value. A set on the same bit wins over the toggle.
- R8: Address 1 holds the 8-bit direction latch and address 2 holds the 16-bit select register, with pin n's field at bits 2n+1:2n. Both read back what was written.
- R9: After reset, every select field is 00 and the direction and data latches are 0, so every pad output enable and every pad output is 0.
- R10: Address 3 reads as 0, and a write to it changes no latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 2 | Register address |
| regWrEn | input | 1 | Register write enable |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data, combinational |
| setMask | input | 8 | Per-bit set of data latch |
| clrMask | input | 8 | Per-bit clear of data latch |
| tglMask | input | 8 | Per-bit invert of data latch |
| padIn | input | 8 | Pad input levels |
| padOut | output | 8 | Pad output values |
| padOe | output | 8 | Pad output enables |
| periphOut | input | 24 | Peripheral 1..3 output values, 8 bits each |
| periphOe | input | 24 | Peripheral 1..3 output enables, 8 bits each |
| periphIn | output | 24 | Pad input presented to peripherals 1..3 |

## Verification
Several data latch updates can land in the same cycle on the same bit: a register write to address 0 and any mix of set, clear and toggle masks. The random phase drives sparse masks together with frequent data writes, so these overlaps happen often. Directed cases also force set with clear, toggle with set, and a write together with a toggle and a clear. Each result is judged on the pad output of a pin left in GPIO mode, compared with a bench model that applies clear over set over toggle over write.

// File: rtl/gpm_pkg.sv
package gpm_pkg;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_DIR  = 2'd1;
  localparam logic [1:0] ADDR_SEL  = 2'd2;

  typedef enum logic [1:0] {
    RD_PAD  = 2'd0,
    RD_DIR  = 2'd1,
    RD_SEL  = 2'd2,
    RD_ZERO = 2'd3
  } gpmRdSrc_t;

  typedef struct packed {
    logic      wrData;
    logic      wrDir;
    logic      wrSel;
    gpmRdSrc_t rdSrc;
  } gpmStrobes_t;

endpackage

// File: rtl/gpm_ctrl.sv
module gpm_ctrl
  import gpm_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output gpmStrobes_t       strb
);

  always_comb begin
    strb        = '0;
    strb.rdSrc  = RD_ZERO;
    unique case (regAddr)
      ADDR_DATA: begin
        strb.wrData = regWrEn;
        strb.rdSrc  = RD_PAD;
      end
      ADDR_DIR: begin
        strb.wrDir = regWrEn;
        strb.rdSrc = RD_DIR;
      end
      ADDR_SEL: begin
        strb.wrSel = regWrEn;
        strb.rdSrc = RD_SEL;
      end
      default: strb.rdSrc = RD_ZERO;
    endcase
  end

endmodule

// File: rtl/gpm_datapath.sv
module gpm_datapath
  import gpm_pkg::*;
#(
  parameter int PIN_COUNT = 8,
  parameter int SEL_W     = 2,
  localparam int REG_W    = SEL_W * PIN_COUNT
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  gpmStrobes_t          strb,
  input  logic [REG_W-1:0]     regWrData,
  input  logic [PIN_COUNT-1:0] setMask,
  input  logic [PIN_COUNT-1:0] clrMask,
  input  logic [PIN_COUNT-1:0] tglMask,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] dataQ,
  output logic [PIN_COUNT-1:0] dirQ,
  output logic [REG_W-1:0]     selQ,
  output logic [REG_W-1:0]     regRdData
);

  logic [PIN_COUNT-1:0] dataBase;
  logic [PIN_COUNT-1:0] dataD;

  // write first, then toggle, then set, then clear (clear wins)
  always_comb begin
    dataBase = strb.wrData ? regWrData[PIN_COUNT-1:0] : dataQ;
    dataD    = ((dataBase ^ tglMask) | setMask) & ~clrMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;
      dirQ  <= '0;
      selQ  <= '0;
    end else begin
      dataQ <= dataD;
      if (strb.wrDir) dirQ <= regWrData[PIN_COUNT-1:0];
      if (strb.wrSel) selQ <= regWrData;
    end
  end

  always_comb begin
    regRdData = '0;
    unique case (strb.rdSrc)
      RD_PAD:  regRdData[PIN_COUNT-1:0] = padIn;
      RD_DIR:  regRdData[PIN_COUNT-1:0] = dirQ;
      RD_SEL:  regRdData                = selQ;
      default: regRdData                = '0;
    endcase
  end

  // R6: a cleared bit is 0 after the edge
  assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((dataQ & $past(clrMask)) == '0));

  // R5: a set bit without clear is 1 after the edge
  assert_set_bit_R5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((dataQ & $past(setMask & ~clrMask)) == $past(setMask & ~clrMask)));

  // R7: toggle-only bits invert when no register write happens
  assert_toggle_inv_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrData |=> (((dataQ ^ $past(dataQ)) & $past(tglMask & ~setMask & ~clrMask))
                      == $past(tglMask & ~setMask & ~clrMask)));

  // R5: untouched bits hold when no register write happens
  assert_hold_untouched_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrData |=> (((dataQ ^ $past(dataQ)) & ~$past(tglMask | setMask | clrMask)) == '0));

  // R8: direction latch changes only on its write strobe
  assert_dir_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrDir |=> $stable(dirQ));

  // R10: select register changes only on its write strobe
  assert_sel_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrSel |=> $stable(selQ));

endmodule

// File: rtl/gpm_pin_mux.sv
module gpm_pin_mux #(
  parameter int NUM_PERIPH = 3,
  parameter int SEL_W      = 2
) (
  input  logic [SEL_W-1:0]      sel,
  input  logic                  gpioOut,
  input  logic                  gpioOe,
  input  logic [NUM_PERIPH-1:0] perOut,
  input  logic [NUM_PERIPH-1:0] perOe,
  output logic                  padOut,
  output logic                  padOe
);

  always_comb begin
    padOut = gpioOut;
    padOe  = gpioOe;
    for (int k = 1; k <= NUM_PERIPH; k++) begin
      if (sel == SEL_W'(k)) begin
        padOut = perOut[k-1];
        padOe  = perOe[k-1];
      end
    end
  end

endmodule

// File: rtl/gpio_mux_bank.sv
module gpio_mux_bank
  import gpm_pkg::*;
#(
  parameter int PIN_COUNT  = 8,
  parameter int NUM_PERIPH = 3,
  parameter int ADDR_W     = 2,
  localparam int SEL_W     = $clog2(NUM_PERIPH + 1),
  localparam int REG_W     = SEL_W * PIN_COUNT,
  localparam int PER_W     = NUM_PERIPH * PIN_COUNT
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [REG_W-1:0]     regWrData,
  output logic [REG_W-1:0]     regRdData,
  input  logic [PIN_COUNT-1:0] setMask,
  input  logic [PIN_COUNT-1:0] clrMask,
  input  logic [PIN_COUNT-1:0] tglMask,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  input  logic [PER_W-1:0]     periphOut,
  input  logic [PER_W-1:0]     periphOe,
  output logic [PER_W-1:0]     periphIn
);

  gpmStrobes_t          strb;
  logic [PIN_COUNT-1:0] dataQ;
  logic [PIN_COUNT-1:0] dirQ;
  logic [REG_W-1:0]     selQ;

  gpm_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strb    (strb)
  );

  gpm_datapath #(.PIN_COUNT(PIN_COUNT), .SEL_W(SEL_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .regWrData (regWrData),
    .setMask   (setMask),
    .clrMask   (clrMask),
    .tglMask   (tglMask),
    .padIn     (padIn),
    .dataQ     (dataQ),
    .dirQ      (dirQ),
    .selQ      (selQ),
    .regRdData (regRdData)
  );

  // every peripheral input path sees the pad level
  assign periphIn = {NUM_PERIPH{padIn}};

  for (genvar p = 0; p < PIN_COUNT; p++) begin : gPin
    logic [NUM_PERIPH-1:0] pinPerOut;
    logic [NUM_PERIPH-1:0] pinPerOe;
    for (genvar k = 0; k < NUM_PERIPH; k++) begin : gSrc
      assign pinPerOut[k] = periphOut[k*PIN_COUNT + p];
      assign pinPerOe[k]  = periphOe[k*PIN_COUNT + p];
    end

    gpm_pin_mux #(.NUM_PERIPH(NUM_PERIPH), .SEL_W(SEL_W)) mux_i (
      .sel     (selQ[p*SEL_W +: SEL_W]),
      .gpioOut (dataQ[p]),
      .gpioOe  (dirQ[p]),
      .perOut  (pinPerOut),
      .perOe   (pinPerOe),
      .padOut  (padOut[p]),
      .padOe   (padOe[p])
    );

    // R1: GPIO mode takes latch data and direction
    assert_gpio_mode_R1: assert property (@(posedge clk) disable iff (!rstN)
      (selQ[p*SEL_W +: SEL_W] == '0) |-> (padOut[p] == dataQ[p] && padOe[p] == dirQ[p]));
  end

  // R9: first cycle out of reset leaves all pads undriven and low
  assert_reset_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (padOe == '0 && padOut == '0));

endmodule

// File: tb/gpio_mux_bank_tb_top.sv
module gpio_mux_bank_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [7:0]  setMask = '0, clrMask = '0, tglMask = '0, padIn = '0;
  logic [7:0]  padOut, padOe;
  logic [23:0] periphOut = '0, periphOe = '0;
  logic [23:0] periphIn;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  logic [7:0]  dataM = '0, dirM = '0;
  logic [15:0] selM = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_mux_bank dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .setMask(setMask),
    .clrMask(clrMask), .tglMask(tglMask), .padIn(padIn), .padOut(padOut),
    .padOe(padOe), .periphOut(periphOut), .periphOe(periphOe), .periphIn(periphIn)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expPad(input logic [15:0] s, input logic [7:0] gpio, input logic [23:0] per);
    logic [7:0] r;
    for (int i = 0; i < NP; i++) begin
      int k = int'(s[2*i +: 2]);
      r[i] = (k == 0) ? gpio[i] : per[(k-1)*NP + i];
    end
    return r;
  endfunction

  function automatic logic [7:0] nextData(input logic [7:0] cur, input bit wr, input logic [7:0] wd,
                                          input logic [7:0] s, input logic [7:0] c, input logic [7:0] t);
    return (((wr ? wd : cur) ^ t) | s) & ~c;
  endfunction

  function automatic logic [15:0] expRead(input logic [1:0] a);
    case (a)
      2'd0: return {8'h00, padIn};
      2'd1: return {8'h00, dirM};
      2'd2: return selM;
      default: return 16'h0000;
    endcase
  endfunction

  // check combinational outputs now, then clock and update the model
  task automatic stepCheck();
    #1;
    check(padOut == expPad(selM, dataM, periphOut), "R1 or R2 padOut", padOut, expPad(selM, dataM, periphOut));
    check(padOe == expPad(selM, dirM, periphOe), "R1 or R2 padOe", padOe, expPad(selM, dirM, periphOe));
    check(periphIn == {3{padIn}}, "R3 periphIn", periphIn, {3{padIn}});
    check(regRdData == expRead(regAddr),
          (regAddr == 2'd0) ? "R4 read pad" : (regAddr == 2'd3) ? "R10 read zero" : "R8 read reg",
          regRdData, expRead(regAddr));
    begin
      logic [7:0] nd = nextData(dataM, regWrEn && regAddr == 2'd0, regWrData[7:0], setMask, clrMask, tglMask);
      logic [7:0] ndir = (regWrEn && regAddr == 2'd1) ? regWrData[7:0] : dirM;
      logic [15:0] nsel = (regWrEn && regAddr == 2'd2) ? regWrData : selM;
      @(posedge clk);
      dataM = nd; dirM = ndir; selM = nsel;
    end
    @(negedge clk);
  endtask

  task automatic drive(input logic [1:0] a, input bit we, input logic [15:0] wd,
                       input logic [7:0] s, input logic [7:0] c, input logic [7:0] t);
    regAddr = a; regWrEn = we; regWrData = wd; setMask = s; clrMask = c; tglMask = t;
  endtask

  task automatic idle();
    drive(2'd0, 1'b0, 16'h0, 8'h0, 8'h0, 8'h0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    padIn = 8'hA5;
    periphOut = 24'hFFFFFF; periphOe = 24'hFFFFFF;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(padOe == 8'h00, "R9 padOe after reset", padOe, 8'h00);
    check(padOut == 8'h00, "R9 padOut after reset", padOut, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    regAddr = 2'd2; #1;
    check(regRdData == 16'h0, "R9 select after reset", regRdData, 16'h0);
    regAddr = 2'd1; #1;
    check(regRdData == 16'h0, "R9 direction after reset", regRdData, 16'h0);

    // R6: set and clear on the same bits, clear wins
    drive(2'd0, 1'b0, 16'h0, 8'hFF, 8'h0F, 8'h00); stepCheck();
    idle(); #1;
    check(padOut == 8'hF0, "R6 clear over set", padOut, 8'hF0);
    stepCheck();
    // R7: toggle inverts, set wins over toggle
    drive(2'd0, 1'b0, 16'h0, 8'h03, 8'h00, 8'h33); stepCheck();
    idle(); #1;
    check(padOut == 8'hC3, "R7 toggle with set", padOut, 8'hC3);
    stepCheck();
    // R7 and R6: write, toggle and clear in one cycle
    drive(2'd0, 1'b1, 16'h005A, 8'h00, 8'h01, 8'h0F); stepCheck();
    idle(); #1;
    check(padOut == 8'h54, "R7 toggle on written value", padOut, 8'h54);
    stepCheck();
    // R5: set on some bits, others hold
    drive(2'd0, 1'b0, 16'h0, 8'h80, 8'h00, 8'h00); stepCheck();
    idle(); #1;
    check(padOut == 8'hD4, "R5 set one bit", padOut, 8'hD4);
    stepCheck();
    // R10: write to address 3 changes nothing
    drive(2'd3, 1'b1, 16'hFFFF, 8'h00, 8'h00, 8'h00); stepCheck();
    idle(); regAddr = 2'd2; #1;
    check(regRdData == 16'h0, "R10 select unchanged", regRdData, 16'h0);
    regAddr = 2'd1; #1;
    check(regRdData == 16'h0, "R10 direction unchanged", regRdData, 16'h0);
    check(padOut == 8'hD4, "R10 data unchanged", padOut, 8'hD4);
    // R2: each pin on a different source
    periphOut = 24'h0F_33_55; periphOe = 24'hF0_CC_AA;
    drive(2'd2, 1'b1, 16'b11_10_01_00_11_10_01_00, 8'h0, 8'h0, 8'h0); stepCheck();
    idle(); stepCheck();
    // R4: pad read with several pad levels
    padIn = 8'h3C; drive(2'd0, 1'b0, 16'h0, 8'h0, 8'h0, 8'h0); stepCheck();

    // random phase
    for (int n = 0; n < 3000; n++) begin
      drive(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 16'($urandom),
            8'($urandom & $urandom), 8'($urandom & $urandom), 8'($urandom & $urandom));
      padIn = 8'($urandom);
      periphOut = 24'($urandom); periphOe = 24'($urandom);
      stepCheck();
    end

    // R8: direct write then readback of direction and select
    drive(2'd1, 1'b1, 16'h00E7, 8'h0, 8'h0, 8'h0); stepCheck();
    drive(2'd2, 1'b1, 16'h1B6C, 8'h0, 8'h0, 8'h0); stepCheck();
    idle(); regAddr = 2'd1; #1;
    check(regRdData == 16'h00E7, "R8 direction readback", regRdData, 16'h00E7);
    regAddr = 2'd2; #1;
    check(regRdData == 16'h1B6C, "R8 select readback", regRdData, 16'h1B6C);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule